// File: doc/BRIEF.md
# Per-Line Multichannel HDMA Sequencer

This block drives the per-scanline work of up to eight horizontal-blank transfer channels. A one-cycle strobe at the start of horizontal blank starts two passes. The first pass performs one data read for every armed channel that has a transfer due, in ascending channel order. The second pass then walks the channels again, in ascending order, to step each line counter. When a counter runs out, the block fetches a new table byte and, for indirect channels, a new indirect address. Putting every transfer ahead of every address refetch keeps the data moves early in the blanking window, even in the worst case of eight transfers plus eight address fetches.

All memory traffic uses a single read port with a request/acknowledge handshake. Every byte returned on that port is latched into a shared memory data register, which later open-bus reads return. A separate frame-start strobe re-arms the enabled channels. A table byte of zero retires a channel until the next frame. When the channel that retires is indirect and is the last armed channel of the frame, the block fetches only one address byte, and the indirect address becomes that byte placed in the upper half with a cleared lower half. Register programming and destination writes are handled elsewhere.

Top module: `hdma_seq`

## Requirements
- R1: In the transfer pass, a data read (kind 0) is issued once per line for each channel that is enabled, armed and has a transfer due, in ascending channel order.
- R2: Within a line, every data read completes before any table or address read is issued.
- R3: In the update pass, each enabled armed channel with a count above 1 decrements its count with no read, and its next-line transfer is due only if its repeat flag is set. With a count of 0 or 1, the channel issues a table read (kind 1). A nonzero byte loads bits [6:0] as the count and bit 7 as the repeat flag, and makes a transfer due on the next line.
- R4: A table byte of zero retires the channel. `chan_active_o` drops for that channel and stays low until the next frame-start strobe.
- R5: After a nonzero table byte, an indirect channel reads the address low byte (kind 2) and then the high byte (kind 3). Its `ind_addr_o` field becomes {high, low}.
- R6: A retiring indirect channel that leaves no other enabled armed channel performs exactly one address read (kind 2). Its address becomes {byte, 8'h00}. A retiring channel that is not indirect, or that leaves other channels armed, performs no address read.
- R7: Each completed read (request and acknowledge high at the same clock edge) loads the returned byte into `mdr_o`.
- R8: `busy_o` rises after a blanking strobe taken while idle and falls once both passes finish. Blanking strobes seen while busy are ignored. No request is issued while idle.
- R9: A frame-start strobe taken while idle sets each channel's armed state to its enable, clears the counts and due transfers, and so produces no data read on the first line after it.
- R10: Disabled and retired channels receive no reads in either pass.
- R11: A request holds its kind and channel stable until acknowledged. Kind codes are: 0 data, 1 table, 2 address low or single fetch, 3 address high.
- R12: After reset, `busy_o`, `rd_req_o`, `mdr_o`, `chan_active_o` and `ind_addr_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Frame re-arm strobe |
| hblank_i | input | 1 | Horizontal-blank start strobe |
| chan_en_i | input | 8 | Per-channel enable |
| chan_ind_i | input | 8 | Per-channel indirect mode |
| rd_req_o | output | 1 | Read request |
| rd_kind_o | output | 2 | Read kind code |
| rd_chan_o | output | 3 | Channel of the current request |
| rd_ack_i | input | 1 | Read acknowledge |
| rd_data_i | input | 8 | Returned byte |
| mdr_o | output | 8 | Shared memory data register |
| busy_o | output | 1 | Passes in progress |
| chan_active_o | output | 8 | Per-channel armed (not retired) flag |
| ind_addr_o | output | 128 | Indirect address, 16 bits per channel, channel 0 in the low bits |

## Verification
A wrong pending mask or counter shows up on the read port at once: the kind/channel sequence of that same line diverges, either as a read out of order, a missing or extra read, or a data read after an address read. Bad retirement or last-channel detection shows up at the end of the line in `chan_active_o` and `ind_addr_o`, and in a single-fetch read where a table read or no read was due. Each line is compared read by read against a model line list, so a fault surfaces within the line in which it first matters.

// File: rtl/hdma_pkg.sv
package hdma_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = BYTE_W - 1;
  localparam int unsigned ADDR_W = 2 * BYTE_W;

  typedef enum logic [1:0] {
    RK_DATA    = 2'd0,
    RK_TABLE   = 2'd1,
    RK_ADDR_LO = 2'd2,
    RK_ADDR_HI = 2'd3
  } rd_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_XFER, S_UPD, S_TBL, S_ALO, S_AHI, S_AONE
  } seq_state_e;
endpackage

// File: rtl/hdma_pick.sv
module hdma_pick #(
  parameter int unsigned N   = 8,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  // lowest set bit wins
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/hdma_chan.sv
module hdma_chan
  import hdma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              frame_i,
  input  logic              dec_i,
  input  logic              load_i,
  input  logic              term_i,
  input  logic              lo_i,
  input  logic              hi_i,
  input  logic              one_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              act_o,
  output logic              dox_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic act_q, dox_q, rep_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      dox_q <= 1'b0;
      rep_q <= 1'b0;
      cnt_q <= '0;
    end else if (frame_i) begin
      act_q <= en_i;
      dox_q <= 1'b0;
      rep_q <= 1'b0;
      cnt_q <= '0;
    end else if (dec_i) begin
      cnt_q <= cnt_q - CNT_W'(1);
      dox_q <= rep_q;
    end else if (load_i) begin
      cnt_q <= data_i[CNT_W-1:0];
      rep_q <= data_i[BYTE_W-1];
      dox_q <= 1'b1;
    end else if (term_i) begin
      act_q <= 1'b0;
      dox_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    addr_q <= '0;
    else if (lo_i)  addr_q[BYTE_W-1:0] <= data_i;
    else if (hi_i)  addr_q[ADDR_W-1:BYTE_W] <= data_i;
    else if (one_i) addr_q <= {data_i, {BYTE_W{1'b0}}};
  end

  assign act_o  = act_q;
  assign dox_o  = dox_q;
  assign cnt_o  = cnt_q;
  assign addr_o = addr_q;

  AST_RETIRED_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_q && !frame_i |=> !act_q); // R4
  AST_ADDR_ONLY_ON_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lo_i && !hi_i && !one_i |=> $stable(addr_q)); // R5
endmodule

// File: rtl/hdma_seq.sv
module hdma_seq
  import hdma_pkg::*;
#(
  parameter int unsigned N_CH = 8,
  localparam int unsigned CHW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     frame_start_i,
  input  logic                     hblank_i,
  input  logic [N_CH-1:0]          chan_en_i,
  input  logic [N_CH-1:0]          chan_ind_i,
  output logic                     rd_req_o,
  output logic [1:0]               rd_kind_o,
  output logic [CHW-1:0]           rd_chan_o,
  input  logic                     rd_ack_i,
  input  logic [BYTE_W-1:0]        rd_data_i,
  output logic [BYTE_W-1:0]        mdr_o,
  output logic                     busy_o,
  output logic [N_CH-1:0]          chan_active_o,
  output logic [N_CH*ADDR_W-1:0]   ind_addr_o
);
  seq_state_e state_q, state_d;
  logic [N_CH-1:0] xfer_q, xfer_d, upd_q, upd_d;
  logic [CHW-1:0]  cur_q, cur_d;
  logic [BYTE_W-1:0] mdr_q;

  logic [N_CH-1:0] act_vec, dox_vec, cur_oh, others;
  logic [CNT_W-1:0] cnt_arr [N_CH];
  logic [N_CH-1:0] dec_v, load_v, term_v, lo_v, hi_v, one_v;
  logic frame_go, fire, req;
  rd_kind_e kind;
  logic [CHW-1:0] chan;

  logic [CHW-1:0] x_idx, u_idx;
  logic x_any, u_any;

  hdma_pick #(.N(N_CH)) u_pick_xfer (.req_i(xfer_q), .idx_o(x_idx), .any_o(x_any));
  hdma_pick #(.N(N_CH)) u_pick_upd  (.req_i(upd_q),  .idx_o(u_idx), .any_o(u_any));

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    hdma_chan u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (chan_en_i[g]),
      .frame_i(frame_go),
      .dec_i  (dec_v[g]),
      .load_i (load_v[g]),
      .term_i (term_v[g]),
      .lo_i   (lo_v[g]),
      .hi_i   (hi_v[g]),
      .one_i  (one_v[g]),
      .data_i (rd_data_i),
      .act_o  (act_vec[g]),
      .dox_o  (dox_vec[g]),
      .cnt_o  (cnt_arr[g]),
      .addr_o (ind_addr_o[g*ADDR_W +: ADDR_W])
    );
  end

  assign cur_oh = N_CH'(1) << cur_q;
  assign others = chan_en_i & act_vec & ~cur_oh;
  assign fire   = req & rd_ack_i;

  always_comb begin
    state_d  = state_q;
    xfer_d   = xfer_q;
    upd_d    = upd_q;
    cur_d    = cur_q;
    req      = 1'b0;
    kind     = RK_DATA;
    chan     = cur_q;
    frame_go = 1'b0;
    dec_v    = '0;
    load_v   = '0;
    term_v   = '0;
    lo_v     = '0;
    hi_v     = '0;
    one_v    = '0;
    unique case (state_q)
      S_IDLE: begin
        if (hblank_i) begin
          xfer_d  = chan_en_i & act_vec & dox_vec;
          upd_d   = chan_en_i & act_vec;
          state_d = S_XFER;
        end else if (frame_start_i) begin
          frame_go = 1'b1;
        end
      end
      S_XFER: begin
        if (!x_any) begin
          state_d = S_UPD;
        end else begin
          req  = 1'b1;
          kind = RK_DATA;
          chan = x_idx;
          if (fire) xfer_d[x_idx] = 1'b0;
        end
      end
      S_UPD: begin
        if (!u_any) begin
          state_d = S_IDLE;
        end else begin
          cur_d        = u_idx;
          upd_d[u_idx] = 1'b0;
          if (cnt_arr[u_idx] > CNT_W'(1)) dec_v[u_idx] = 1'b1;
          else                            state_d = S_TBL;
        end
      end
      S_TBL: begin
        req  = 1'b1;
        kind = RK_TABLE;
        if (fire) begin
          if (rd_data_i == '0) begin
            term_v[cur_q] = 1'b1;
            // last armed indirect channel: single address fetch
            state_d = (chan_ind_i[cur_q] && others == '0) ? S_AONE : S_UPD;
          end else begin
            load_v[cur_q] = 1'b1;
            state_d = chan_ind_i[cur_q] ? S_ALO : S_UPD;
          end
        end
      end
      S_ALO: begin
        req  = 1'b1;
        kind = RK_ADDR_LO;
        if (fire) begin
          lo_v[cur_q] = 1'b1;
          state_d     = S_AHI;
        end
      end
      S_AHI: begin
        req  = 1'b1;
        kind = RK_ADDR_HI;
        if (fire) begin
          hi_v[cur_q] = 1'b1;
          state_d     = S_UPD;
        end
      end
      S_AONE: begin
        req  = 1'b1;
        kind = RK_ADDR_LO;
        if (fire) begin
          one_v[cur_q] = 1'b1;
          state_d      = S_UPD;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      xfer_q  <= '0;
      upd_q   <= '0;
      cur_q   <= '0;
      mdr_q   <= '0;
    end else begin
      state_q <= state_d;
      xfer_q  <= xfer_d;
      upd_q   <= upd_d;
      cur_q   <= cur_d;
      if (fire) mdr_q <= rd_data_i;
    end
  end

  assign rd_req_o      = req;
  assign rd_kind_o     = kind;
  assign rd_chan_o     = chan;
  assign mdr_o         = mdr_q;
  assign busy_o        = (state_q != S_IDLE);
  assign chan_active_o = act_vec;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_kind_o) && $stable(rd_chan_o)); // R11
  AST_NO_REQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !rd_req_o); // R8
  AST_XFER_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && rd_kind_o != RK_DATA |-> xfer_q == '0); // R2
  AST_MDR_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && rd_ack_i |=> mdr_o == $past(rd_data_i)); // R7
  AST_SINGLE_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_AONE |-> (chan_en_i & act_vec) == '0); // R6
  AST_NO_RETIRED_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && (rd_kind_o == RK_DATA || rd_kind_o == RK_TABLE) |-> act_vec[rd_chan_o]); // R10
endmodule

// File: tb/hdma_seq_test.sv
module hdma_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_start = 1'b0, hblank = 1'b0;
  logic [N-1:0] en = '0, ind = '0;
  logic rd_req, rd_ack = 1'b0;
  logic [1:0] rd_kind;
  logic [2:0] rd_chan;
  logic [7:0] rd_data = '0, mdr;
  logic busy;
  logic [N-1:0] act;
  logic [N*16-1:0] addr;

  hdma_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(frame_start), .hblank_i(hblank),
    .chan_en_i(en), .chan_ind_i(ind), .rd_req_o(rd_req), .rd_kind_o(rd_kind),
    .rd_chan_o(rd_chan), .rd_ack_i(rd_ack), .rd_data_i(rd_data), .mdr_o(mdr),
    .busy_o(busy), .chan_active_o(act), .ind_addr_o(addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  bit m_act[N], m_dox[N], m_rep[N];
  int m_cnt[N], ti[N];
  logic [15:0] m_addr[N];
  logic [7:0] m_mdr = '0;
  logic [7:0] tbl[N][8];
  int ek[64], ec[64];
  logic [7:0] ed[64];
  int n;
  int obs_data, obs_dis;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] a, input logic [31:0] e);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, a, e);
    end
  endtask

  task automatic push(input int k, input int c, input logic [7:0] d);
    ek[n] = k; ec[n] = c; ed[n] = d; n++;
  endtask

  function automatic bit none_left();
    for (int i = 0; i < N; i++) if (en[i] && m_act[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic build_line();
    n = 0;
    for (int c = 0; c < N; c++)
      if (en[c] && m_act[c] && m_dox[c]) push(0, c, 8'($urandom));
    for (int c = 0; c < N; c++) begin
      if (en[c] && m_act[c]) begin
        if (m_cnt[c] > 1) begin
          m_cnt[c]--; m_dox[c] = m_rep[c];
        end else begin
          logic [7:0] b;
          b = tbl[c][ti[c]]; ti[c]++;
          push(1, c, b);
          if (b == 0) begin
            m_act[c] = 0; m_dox[c] = 0;
            if (ind[c] && none_left()) begin
              logic [7:0] lo;
              lo = 8'($urandom);
              push(2, c, lo);
              m_addr[c] = {lo, 8'h00};
            end
          end else begin
            m_cnt[c] = int'(b[6:0]); m_rep[c] = b[7]; m_dox[c] = 1;
            if (ind[c]) begin
              logic [7:0] lo, hi;
              lo = 8'($urandom); hi = 8'($urandom);
              push(2, c, lo); push(3, c, hi);
              m_addr[c] = {hi, lo};
            end
          end
        end
      end
    end
  endtask

  task automatic do_frame();
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
    for (int c = 0; c < N; c++) begin
      m_act[c] = en[c]; m_dox[c] = 0; m_rep[c] = 0; m_cnt[c] = 0; ti[c] = 0;
    end
  endtask

  task automatic run_line(input bit inject);
    int idx, lat, it;
    bit waiting;
    logic [1:0] pk;
    logic [2:0] pc;
    build_line();
    idx = 0; lat = $urandom % 3; it = 0; waiting = 0; pk = '0; pc = '0;
    obs_data = 0; obs_dis = 0;
    @(negedge clk) hblank = 1'b1;
    forever begin
      @(negedge clk);
      rd_ack = 1'b0; hblank = 1'b0;
      if (!busy) break;
      it++;
      if (inject && it == 3) hblank = 1'b1;
      if (rd_req) begin
        if (!en[rd_chan]) obs_dis++;
        if (waiting)
          chk(rd_kind == pk && rd_chan == pc, "R11", "request changed before ack",
              {rd_kind, rd_chan}, {pk, pc});
        if (lat > 0) begin
          lat--; waiting = 1; pk = rd_kind; pc = rd_chan;
        end else begin
          if (idx < n) begin
            case (ek[idx])
              0: chk(rd_kind == 2'd0 && rd_chan == 3'(ec[idx]), "R1", "data read",
                     {rd_kind, rd_chan}, {2'(ek[idx]), 3'(ec[idx])});
              1: chk(rd_kind == 2'd1 && rd_chan == 3'(ec[idx]), "R3", "table read",
                     {rd_kind, rd_chan}, {2'(ek[idx]), 3'(ec[idx])});
              default: chk(rd_kind == 2'(ek[idx]) && rd_chan == 3'(ec[idx]), "R5", "address read",
                     {rd_kind, rd_chan}, {2'(ek[idx]), 3'(ec[idx])});
            endcase
            rd_data = ed[idx];
          end else begin
            chk(1'b0, "R8", "extra read", {rd_kind, rd_chan}, 0);
            rd_data = '0;
          end
          if (rd_kind == 2'd0) obs_data++;
          rd_ack = 1'b1; idx++; waiting = 0; lat = $urandom % 3;
        end
      end
    end
    chk(idx == n, "R8", "read count in line", idx, n);
    chk(obs_dis == 0, "R10", "reads to disabled channels", obs_dis, 0);
    if (n > 0) m_mdr = ed[n-1];
    chk(mdr == m_mdr, "R7", "mdr after line", mdr, m_mdr);
    for (int c = 0; c < N; c++) begin
      chk(act[c] == m_act[c], "R4", "channel active", act[c], m_act[c]);
      chk(addr[c*16 +: 16] == m_addr[c], "R5/R6", "indirect address", addr[c*16 +: 16], m_addr[c]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL R8 watchdog expired: actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1d5));
    for (int c = 0; c < N; c++) begin
      m_addr[c] = '0; m_act[c] = 0; m_dox[c] = 0; m_rep[c] = 0; m_cnt[c] = 0; ti[c] = 0;
      for (int j = 0; j < 8; j++) tbl[c][j] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(!busy && !rd_req, "R12", "busy/req after reset", {busy, rd_req}, 0);
    chk(mdr == 0, "R12", "mdr after reset", mdr, 0);
    chk(act == 0 && addr == 0, "R12", "channel state after reset", act, 0);

    // directed: all eight indirect channels, worst-case line then all retire
    en = 8'hFF; ind = 8'hFF;
    for (int c = 0; c < N; c++) begin tbl[c][0] = 8'h81; tbl[c][1] = 8'h00; end
    do_frame();
    run_line(0);
    chk(obs_data == 0, "R9", "data reads on first line after frame start", obs_data, 0);
    run_line(1);
    chk(obs_data == 8, "R2", "eight transfers in worst-case line", obs_data, 8);
    run_line(0);
    chk(!busy && !rd_req, "R8", "idle after passes", {busy, rd_req}, 0);

    // directed: single indirect channel, no repeat, retires last
    en = 8'h20; ind = 8'h20;
    tbl[5][0] = 8'h02; tbl[5][1] = 8'h00;
    do_frame();
    for (int l = 0; l < 4; l++) run_line(l == 1);
    chk(addr[5*16 +: 8] == 8'h00, "R6", "single fetch clears low byte", addr[5*16 +: 8], 0);

    // directed: direct-mode last channel retires without address read
    en = 8'h08; ind = 8'h00;
    tbl[3][0] = 8'h01; tbl[3][1] = 8'h00;
    do_frame();
    for (int l = 0; l < 3; l++) run_line(0);

    // random frames
    for (int f = 0; f < 8; f++) begin
      en = 8'($urandom); ind = 8'($urandom);
      for (int c = 0; c < N; c++) begin
        int len;
        len = $urandom % 4;
        for (int j = 0; j < 8; j++) tbl[c][j] = '0;
        for (int j = 0; j < len; j++)
          tbl[c][j] = {1'($urandom), 7'(1 + $urandom % 3)};
      end
      do_frame();
      for (int l = 0; l < 12; l++) run_line(($urandom % 4) == 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule